// File: doc/BRIEF.md
# Microprogram Sequencer with Address Bit-ORing

This block is the sequencing core of a microprogrammed control unit. A micro-address register selects one word of a constant control store inside the block. Each word carries three things: the control signals for that step, a sequencing type and a target field. By default the address advances by one after every step. Special words can return to zero at the end of an instruction, branch on the sign flag, or perform a multi-way dispatch. The dispatch forms its target by ORing instruction-register fields into chosen address bits on top of a fixed base, so no dispatch table is needed.

The control store holds a shared instruction fetch, a dispatch step, a register-indirect autoincrement source routine with a shared add tail, and a branch-on-negative routine. A step flagged as waiting for memory freezes the address until memory-function-complete is seen. Control and status pins are plain levels. No stream interface is involved, so there is no valid/ready handshake and no back-pressure.

Top module: `micro_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the micro-address to 0. While reset is high, and in the first cycle after it, the outputs show word 0.
- R2: Words 0, 1 and 2 form the fetch and advance by one. Word 0's control vector is exactly 0x003F: bit 0 PC drive, bit 1 MAR load, bit 2 read, bit 3 constant-4 select, bit 4 add, bit 5 Z load.
- R3: While the current word has its wait flag set and `mfc` is low, the micro-address holds and `wait_mfc` is 1. When `mfc` is 1, the word's normal sequencing takes effect. Words 1, octal 123 and octal 170 carry the wait flag.
- R4: At word 3 with `ir_fields[3]`=0, the next address is octal 101. Mode bit 2 (`ir_fields[2]`) is ORed into address bit 5, and mode bit 1 into address bit 4. The product of mode bit 2 and mode bit 0 is ORed into address bit 3. Mode 010 therefore lands at octal 121, mode 101 at octal 151, and mode 111 at octal 171.
- R5: At word 3 with `ir_fields[3]`=1 (branch-class opcode), the next address is octal 031 and no bits are ORed in.
- R6: Word octal 123 branches to octal 170, with address bit 0 set to the inverse of mode bit 0. Mode 010 therefore goes 123 -> 171 and skips 170, while mode 011 goes 123 -> 170.
- R7: Word octal 031 branches to 0 when `n_flag` is 0. Otherwise it proceeds to 032 and then 033.
- R8: A word marked end (octal 033 and octal 173) drives `end_op`=1, and the next address is 0.
- R9: Every unused control-store word behaves as an end word. Mode 000 dispatches to octal 101 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_fields | input | 4 | Bit 3: branch-class opcode; bits 2:0: addressing mode |
| n_flag | input | 1 | Negative condition flag |
| mfc | input | 1 | Memory function complete |
| upc | output | 7 | Current micro-address |
| ctrl | output | 17 | Control signals of the current word |
| wait_mfc | output | 1 | Current word waits for memory |
| end_op | output | 1 | Current word ends the instruction |

## Verification
The bench targets the skipped location at octal 170. A design that takes bit 0 from the mode bit without inverting it would visit 170 for mode 010 and skip it for mode 011. Dispatches with modes 101 and 111 exercise the product term in bit 3; a wrong product sends those modes to a neighbouring routine entry. Stall windows at all three waiting words, with `mfc` held low, expose a sequencer that advances early or does not stall at all. Both outcomes of the branch on `n_flag`, and the fall into unused words, catch inverted conditions and stray addresses.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UAW   = 7;
  localparam int DEPTH = 1 << UAW;
  localparam int IRF   = 4;
  localparam int CW    = 17;

  localparam int C_PC_OUT   = 0;
  localparam int C_MAR_IN   = 1;
  localparam int C_RD       = 2;
  localparam int C_SEL4     = 3;
  localparam int C_ADD      = 4;
  localparam int C_Z_IN     = 5;
  localparam int C_Z_OUT    = 6;
  localparam int C_PC_IN    = 7;
  localparam int C_Y_IN     = 8;
  localparam int C_MDR_OUT  = 9;
  localparam int C_IR_IN    = 10;
  localparam int C_OFS_OUT  = 11;
  localparam int C_SELY     = 12;
  localparam int C_RSRC_OUT = 13;
  localparam int C_RSRC_IN  = 14;
  localparam int C_RDST_OUT = 15;
  localparam int C_RDST_IN  = 16;

  localparam int M_BRCLASS = 3;
  localparam int M_HI      = 2;
  localparam int M_MID     = 1;
  localparam int M_LO      = 0;

  typedef enum logic [2:0] {
    SQ_NEXT, SQ_DISPATCH, SQ_ORSKIP, SQ_BRNZ, SQ_END
  } seq_e;

  typedef struct packed {
    seq_e             seq;
    logic             wmfc;
    logic [UAW-1:0]   target;
    logic [CW-1:0]    ctrl;
  } uword_t;

  function automatic logic [CW-1:0] cb(input int i);
    return CW'(1) << i;
  endfunction

  function automatic uword_t store_word(input int unsigned a);
    uword_t w;
    w.seq    = SQ_END;
    w.wmfc   = 1'b0;
    w.target = '0;
    w.ctrl   = '0;
    case (a)
      0: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_PC_OUT) | cb(C_MAR_IN) | cb(C_RD) | cb(C_SEL4) | cb(C_ADD) | cb(C_Z_IN);
      end
      1: begin
        w.seq  = SQ_NEXT;
        w.wmfc = 1'b1;
        w.ctrl = cb(C_Z_OUT) | cb(C_PC_IN) | cb(C_Y_IN);
      end
      2: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_MDR_OUT) | cb(C_IR_IN);
      end
      3: w.seq = SQ_DISPATCH;
      'o031: begin
        w.seq    = SQ_BRNZ;
        w.target = '0;
      end
      'o032: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_OFS_OUT) | cb(C_SELY) | cb(C_ADD) | cb(C_Z_IN);
      end
      'o033: w.ctrl = cb(C_Z_OUT) | cb(C_PC_IN);
      'o121: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_RSRC_OUT) | cb(C_MAR_IN) | cb(C_RD) | cb(C_SEL4) | cb(C_ADD) | cb(C_Z_IN);
      end
      'o122: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_Z_OUT) | cb(C_RSRC_IN);
      end
      'o123: begin
        w.seq    = SQ_ORSKIP;
        w.wmfc   = 1'b1;
        w.target = UAW'('o170);
      end
      'o170: begin
        w.seq  = SQ_NEXT;
        w.wmfc = 1'b1;
        w.ctrl = cb(C_MDR_OUT) | cb(C_MAR_IN) | cb(C_RD);
      end
      'o171: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_MDR_OUT) | cb(C_Y_IN);
      end
      'o172: begin
        w.seq  = SQ_NEXT;
        w.ctrl = cb(C_RDST_OUT) | cb(C_SELY) | cb(C_ADD) | cb(C_Z_IN);
      end
      'o173: w.ctrl = cb(C_Z_OUT) | cb(C_RDST_IN);
      default: ;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UAW-1:0] addr,
  output uword_t         word
);
  uword_t rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign rom[gi] = store_word(gi);
  end

  assign word = rom[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  seq_e           seq,
  input  logic           wmfc,
  input  logic [UAW-1:0] target,
  input  logic [UAW-1:0] upc,
  input  logic [IRF-1:0] ir_fields,
  input  logic           n_flag,
  input  logic           mfc,
  output logic           stall,
  output logic [UAW-1:0] nxt
);
  localparam logic [UAW-1:0] BASE_MODE = UAW'('o101);
  localparam logic [UAW-1:0] BASE_BR   = UAW'('o031);

  logic [UAW-1:0] incr;
  logic [UAW-1:0] or_bits;
  logic [UAW-1:0] disp;

  assign incr  = upc + UAW'(1);
  assign stall = wmfc & ~mfc;

  always_comb begin
    or_bits    = '0;
    or_bits[5] = ir_fields[M_HI];
    or_bits[4] = ir_fields[M_MID];
    or_bits[3] = ir_fields[M_HI] & ir_fields[M_LO];
    disp       = ir_fields[M_BRCLASS] ? BASE_BR : (BASE_MODE | or_bits);
  end

  always_comb begin
    case (seq)
      SQ_NEXT:     nxt = incr;
      SQ_DISPATCH: nxt = disp;
      SQ_ORSKIP:   nxt = {target[UAW-1:1], target[0] | ~ir_fields[M_LO]};
      SQ_BRNZ:     nxt = n_flag ? incr : target;
      default:     nxt = '0;
    endcase
  end
endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
  import useq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [IRF-1:0] ir_fields,
  input  logic           n_flag,
  input  logic           mfc,
  output logic [UAW-1:0] upc,
  output logic [CW-1:0]  ctrl,
  output logic           wait_mfc,
  output logic           end_op
);
  logic [UAW-1:0] upc_q;
  logic [UAW-1:0] nxt;
  logic           stall;
  uword_t         word;

  useq_store i_store (
    .addr (upc_q),
    .word (word)
  );

  useq_next i_next (
    .seq       (word.seq),
    .wmfc      (word.wmfc),
    .target    (word.target),
    .upc       (upc_q),
    .ir_fields (ir_fields),
    .n_flag    (n_flag),
    .mfc       (mfc),
    .stall     (stall),
    .nxt       (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)        upc_q <= '0;
    else if (!stall) upc_q <= nxt;
  end

  assign upc      = upc_q;
  assign ctrl     = word.ctrl;
  assign wait_mfc = word.wmfc;
  assign end_op   = (word.seq == SQ_END);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> upc_q == '0);

  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (word.wmfc && !mfc) |=> $stable(upc_q));

  a_r4_mode_dispatch: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_DISPATCH && !ir_fields[M_BRCLASS])
      |=> (upc_q[6] && upc_q[0] && upc_q[2:1] == 2'b00));

  a_r5_branch_dispatch: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_DISPATCH && ir_fields[M_BRCLASS]) |=> upc_q == UAW'('o031));

  a_r6_tail_entry: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_ORSKIP && mfc)
      |=> ((upc_q | UAW'(1)) == UAW'('o171) && upc_q[0] == !$past(ir_fields[M_LO])));

  a_r7_n_clear_exit: assert property (@(posedge clk) disable iff (rst)
    (word.seq == SQ_BRNZ && !n_flag) |=> upc_q == '0);

  a_r8_end_zero: assert property (@(posedge clk) disable iff (rst)
    (end_op && !wait_mfc) |=> upc_q == '0);
endmodule

// File: tb/test_micro_sequencer.sv
`timescale 1ns/1ps
module test_micro_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ir_fields = 4'b0000;
  logic        n_flag = 1'b0;
  logic        mfc = 1'b1;
  logic [6:0]  upc;
  logic [16:0] ctrl;
  logic        wait_mfc;
  logic        end_op;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  micro_sequencer i_micro_sequencer (
    .clk (clk), .rst (rst), .ir_fields (ir_fields), .n_flag (n_flag),
    .mfc (mfc), .upc (upc), .ctrl (ctrl), .wait_mfc (wait_mfc), .end_op (end_op)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int model_next(input int a, input logic [3:0] f,
                                    input logic n, input logic m);
    if ((a == 1 || a == 'o123 || a == 'o170) && !m) return a;
    case (a)
      0, 1, 2, 'o032, 'o121, 'o122, 'o170, 'o171, 'o172: return a + 1;
      3: begin
        if (f[3]) return 'o031;
        return 'o101 | (int'(f[2]) << 5) | (int'(f[1]) << 4) | (int'(f[2] & f[0]) << 3);
      end
      'o031: return n ? 'o032 : 0;
      'o123: return 'o170 | (f[0] ? 0 : 1);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int a, input logic m);
    if ((a == 1 || a == 'o123 || a == 'o170) && !m) return "R3";
    case (a)
      0, 1, 2: return "R2";
      3: return "R4";
      'o031: return "R7";
      'o123: return "R6";
      'o033, 'o173: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic run_fetch(input logic [3:0] f);
    ir_fields = f;
    mfc = 1'b1;
    step(); chk("R2 fetch 0->1", upc, 1);
    step(); chk("R2 fetch 1->2", upc, 2);
    step(); chk("R2 fetch 2->3", upc, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cur;
    int exp;
    logic [3:0] f;
    logic n;
    logic m;
    void'($urandom(32'd4242));

    // R1: reset state
    do_reset();
    chk("R1 upc after reset", upc, 0);
    chk("R2 word 0 control", ctrl, 'h003F);
    chk("R1 no wait at word 0", wait_mfc, 0);

    // R3: stall at word 1
    mfc = 1'b1;
    step(); chk("R2 fetch 0->1", upc, 1);
    mfc = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(); chk("R3 hold while mfc low", upc, 1);
      chk("R3 wait flag", wait_mfc, 1);
    end
    mfc = 1'b1;
    step(); chk("R3 release on mfc", upc, 2);
    step(); chk("R2 fetch 2->3", upc, 3);

    // R4 / R6: mode 010 skips 170
    ir_fields = 4'b0010;
    step(); chk("R4 mode 010 entry", upc, 'o121);
    step(); chk("R4 routine step", upc, 'o122);
    step(); chk("R4 routine step", upc, 'o123);
    mfc = 1'b0;
    step(); chk("R3 hold at 123", upc, 'o123);
    mfc = 1'b1;
    step(); chk("R6 skip to 171", upc, 'o171);
    step(); chk("R6 tail", upc, 'o172);
    step(); chk("R6 tail", upc, 'o173);
    chk("R8 end flag at 173", end_op, 1);
    step(); chk("R8 end returns to 0", upc, 0);

    // R6: mode 011 visits 170
    run_fetch(4'b0011);
    step(); chk("R4 mode 011 entry", upc, 'o121);
    step(); step();
    step(); chk("R6 mode 011 lands at 170", upc, 'o170);
    mfc = 1'b0;
    step(); chk("R3 hold at 170", upc, 'o170);
    mfc = 1'b1;
    step(); chk("R6 170->171", upc, 'o171);
    step(); step(); step(); chk("R8 back to 0", upc, 0);

    // R5 / R7: branch class, N clear
    run_fetch(4'b1000);
    n_flag = 1'b0;
    step(); chk("R5 branch dispatch", upc, 'o031);
    step(); chk("R7 N=0 goes to 0", upc, 0);

    // R7: N set
    run_fetch(4'b1000);
    n_flag = 1'b1;
    step(); chk("R5 branch dispatch", upc, 'o031);
    step(); chk("R7 N=1 continues", upc, 'o032);
    step(); chk("R7 offset then end word", upc, 'o033);
    chk("R8 end flag at 033", end_op, 1);
    step(); chk("R8 end returns to 0", upc, 0);

    // R9: mode 000 hits unused word
    run_fetch(4'b0000);
    step(); chk("R9 mode 000 entry", upc, 'o101);
    chk("R9 unused word acts as end", end_op, 1);
    step(); chk("R9 unused returns to 0", upc, 0);

    // R4: product term in bit 3
    run_fetch(4'b0101);
    step(); chk("R4 mode 101 entry", upc, 'o151);
    step(); chk("R9 unused returns to 0", upc, 0);
    run_fetch(4'b0111);
    step(); chk("R4 mode 111 entry", upc, 'o171);

    // Random phase
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      cur = upc;
      f = 4'($urandom_range(0, 15));
      n = 1'($urandom_range(0, 1));
      m = ($urandom_range(0, 3) != 0);
      ir_fields = f;
      n_flag = n;
      mfc = m;
      exp = model_next(cur, f, n, m);
      step();
      chk(tag_of(cur, m), upc, exp);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule